// File: doc/BRIEF.md
# Receive Descriptor Completion Engine

This block is the receive side of a descriptor-ring DMA controller. A frame arrives as a request that carries its byte length and its first six destination-address bytes. While reception is enabled and the engine is idle, it takes the request and reads the descriptor at the current ring pointer. If software owns that descriptor, the engine hands the payload move to an external mover, aimed at the descriptor's first buffer. It then writes back a finished control/status word and moves the ring pointer on.

Each outcome leaves a mark in a small set of sticky status flags. Good frames also update four 64-bit statistics counters: frames, bytes, multicast and broadcast. Frames that are too short never reach the ring. When the descriptor is not owned by the engine, the frame is thrown away and a buffer-unavailable condition is flagged. Every memory-side step is a request/done handshake, so the block works with any bus fabric.

Top module: `rx_desc_engine`

## Requirements
- R1: A frame request (`frm_valid` with `frm_ready`) is taken only while the engine is idle and bit 1 of `dma_ctrl` is 1. While that bit is 0, `frm_ready` stays low and requests have no effect.
- R2: A frame with length below 12 is dropped at once. No descriptor read is issued, the counters and the ring pointer are unchanged, and status bits 0 and 1 are set.
- R3: The descriptor read is addressed at the current ring pointer. If bit 31 of the returned control word is 0, no payload or writeback request follows, the pointer is unchanged, and status bits 2 and 3 are set.
- R4: For an owned descriptor, the payload request carries the descriptor's buffer-1 address and the frame length.
- R5: The writeback goes to the current ring pointer with the word ((length + 4) << 16) | 0x300. Ownership bit 31 is therefore cleared and both segment flags (bits 8 and 9) are set.
- R6: After writeback, the ring pointer becomes the ring base when bit 15 of the descriptor's buffer-1 size field is 1, and otherwise advances by 32. A write to the base (`base_wr`) loads both the base and the pointer.
- R7: The destination byte in `frm_dst[7:0]` is the first byte on the wire. A frame is unicast if bit 0 of that byte is 0, broadcast if all six bytes are 0xFF, and multicast otherwise. A good frame increments the multicast or broadcast counter to match its class, and a unicast frame touches neither.
- R8: Each good frame adds 1 to the frame counter and length + 4 to the byte counter. Dropped frames change no counter.
- R9: A good frame sets status bits 0 and 1. The `sts` bit map is: 0 receive done, 1 normal summary, 2 buffer unavailable, 3 abnormal summary. Each bit stays set until a 1 on the matching `sts_clr` bit clears it.
- R10: At most one of the descriptor-read, payload and writeback requests is active at a time, and each stays asserted until its done/ack input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_ctrl | input | 32 | DMA control word; bit 1 enables reception |
| base_wr | input | 1 | Load ring base and ring pointer |
| base_data | input | AW | New ring base |
| cur_ptr | output | AW | Current receive descriptor address |
| frm_valid | input | 1 | Frame request present |
| frm_ready | output | 1 | Engine can take a frame |
| frm_len | input | LW | Frame length in bytes |
| frm_dst | input | 48 | Destination address, first byte in bits 7:0 |
| dsc_rd_req | output | 1 | Descriptor read request |
| dsc_rd_addr | output | AW | Descriptor read address |
| dsc_rd_ack | input | 1 | Descriptor data valid |
| dsc_rd_ctl | input | 32 | Descriptor control/status word |
| dsc_rd_b1size | input | 16 | Descriptor buffer-1 size field |
| dsc_rd_b1addr | input | AW | Descriptor buffer-1 address |
| pay_req | output | 1 | Payload move request |
| pay_addr | output | AW | Payload destination address |
| pay_len | output | LW | Payload length |
| pay_done | input | 1 | Payload move finished |
| wb_req | output | 1 | Descriptor writeback request |
| wb_addr | output | AW | Writeback address |
| wb_ctl | output | 32 | Completed control/status word |
| wb_done | input | 1 | Writeback finished |
| sts | output | 4 | Sticky status flags |
| sts_clr | input | 4 | Write-one-to-clear for `sts` |
| cnt_frames | output | CW | Good frame count |
| cnt_bytes | output | CW | Good byte count including 4 per frame |
| cnt_mcast | output | CW | Multicast good frames |
| cnt_bcast | output | CW | Broadcast good frames |

## Verification
The bench goes after the 12-byte edge from both sides. An off-by-one threshold would either fetch a descriptor for an 11-byte frame or drop a 12-byte one, and both show up in the descriptor-read request and the counters. A descriptor without ownership must end the frame before any payload or writeback request and leave the pointer alone. A design that ignored the ownership bit would corrupt memory the software still owns. The wrap flag in the size field is tested against plain advance, the phantom 4 bytes are checked in both the written-back length and the byte counter, and a broadcast address (which also has the multicast bit set) must land in the broadcast counter rather than the multicast one.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int RXEN_BIT  = 1;
    localparam int OWN_BIT   = 31;
    localparam int WRAP_BIT  = 15;
    localparam int CRC_PAD   = 4;
    localparam logic [15:0] SEG_FLAGS = 16'h0300;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_PAY,
        S_WB,
        S_FIN
    } rxd_state_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_SHORT,
        EV_NODESC,
        EV_GOOD
    } rxd_ev_e;

    typedef enum logic [1:0] {
        CL_UNI,
        CL_BCAST,
        CL_MCAST
    } rxd_class_e;

    typedef struct packed {
        logic abn_sum;
        logic buf_unav;
        logic norm_sum;
        logic rx_done;
    } rxd_sts_t;

    function automatic rxd_sts_t sts_for(input rxd_ev_e kind);
        rxd_sts_t s;
        s = '0;
        case (kind)
            EV_SHORT, EV_GOOD: begin
                s.rx_done  = 1'b1;
                s.norm_sum = 1'b1;
            end
            EV_NODESC: begin
                s.buf_unav = 1'b1;
                s.abn_sum  = 1'b1;
            end
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rxd_classify.sv
module rxd_classify
    import rxd_pkg::*;
(
    input  logic [47:0] dst,
    output rxd_class_e  cls
);
    logic first_grp;
    logic all_ones;

    always_comb begin
        first_grp = dst[0];
        all_ones  = &dst;
        if (!first_grp)
            cls = CL_UNI;
        else if (all_ones)
            cls = CL_BCAST;
        else
            cls = CL_MCAST;
    end
endmodule

// File: rtl/rxd_seq.sv
module rxd_seq
    import rxd_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LW         = 16,
    parameter int DESC_BYTES = 32,
    parameter int MIN_LEN    = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   dma_ctrl,
    input  logic          base_wr,
    input  logic [AW-1:0] base_data,
    output logic [AW-1:0] cur_ptr,
    input  logic          frm_valid,
    output logic          frm_ready,
    input  logic [LW-1:0] frm_len,
    input  logic [47:0]   frm_dst,
    output logic          dsc_rd_req,
    output logic [AW-1:0] dsc_rd_addr,
    input  logic          dsc_rd_ack,
    input  logic [31:0]   dsc_rd_ctl,
    input  logic [15:0]   dsc_rd_b1size,
    input  logic [AW-1:0] dsc_rd_b1addr,
    output logic          pay_req,
    output logic [AW-1:0] pay_addr,
    output logic [LW-1:0] pay_len,
    input  logic          pay_done,
    output logic          wb_req,
    output logic [AW-1:0] wb_addr,
    output logic [31:0]   wb_ctl,
    input  logic          wb_done,
    output logic          ev_valid,
    output rxd_ev_e       ev_kind,
    output logic [LW-1:0] ev_len,
    output logic [47:0]   ev_dst
);
    localparam logic [AW-1:0] STEP    = AW'(DESC_BYTES);
    localparam logic [LW-1:0] MIN_L   = LW'(MIN_LEN);
    localparam logic [LW-1:0] PAD_L   = LW'(CRC_PAD);

    rxd_state_e    state;
    rxd_ev_e       kind_q;
    logic [AW-1:0] base_q;
    logic [LW-1:0] len_q;
    logic [47:0]   dst_q;
    logic [15:0]   b1size_q;
    logic [AW-1:0] b1addr_q;
    logic [LW-1:0] len_tot;
    logic          take;

    assign frm_ready = (state == S_IDLE) && dma_ctrl[RXEN_BIT];
    assign take      = frm_valid && frm_ready;
    assign len_tot   = len_q + PAD_L;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            kind_q   <= EV_NONE;
            len_q    <= '0;
            dst_q    <= '0;
            b1size_q <= '0;
            b1addr_q <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (take) begin
                        len_q <= frm_len;
                        dst_q <= frm_dst;
                        if (frm_len < MIN_L) begin
                            kind_q <= EV_SHORT;
                            state  <= S_FIN;
                        end else begin
                            state  <= S_FETCH;
                        end
                    end
                end
                S_FETCH: begin
                    if (dsc_rd_ack) begin
                        b1size_q <= dsc_rd_b1size;
                        b1addr_q <= dsc_rd_b1addr;
                        if (!dsc_rd_ctl[OWN_BIT]) begin
                            kind_q <= EV_NODESC;
                            state  <= S_FIN;
                        end else begin
                            state  <= S_PAY;
                        end
                    end
                end
                S_PAY: begin
                    if (pay_done)
                        state <= S_WB;
                end
                S_WB: begin
                    if (wb_done) begin
                        kind_q <= EV_GOOD;
                        state  <= S_FIN;
                    end
                end
                S_FIN: begin
                    kind_q <= EV_NONE;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            cur_ptr <= '0;
        end else if (base_wr) begin
            base_q  <= base_data;
            cur_ptr <= base_data;
        end else if (state == S_WB && wb_done) begin
            cur_ptr <= b1size_q[WRAP_BIT] ? base_q : cur_ptr + STEP;
        end
    end

    always_comb begin
        dsc_rd_req  = (state == S_FETCH);
        dsc_rd_addr = cur_ptr;
        pay_req     = (state == S_PAY);
        pay_addr    = b1addr_q;
        pay_len     = len_q;
        wb_req      = (state == S_WB);
        wb_addr     = cur_ptr;
        wb_ctl      = {len_tot[15:0], SEG_FLAGS};
        ev_valid    = (state == S_FIN);
        ev_kind     = kind_q;
        ev_len      = len_q;
        ev_dst      = dst_q;
    end

    p_no_accept_off_r1: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !dma_ctrl[RXEN_BIT]) |=> (state == S_IDLE));

    p_short_skip_r2: assert property (@(posedge clk) disable iff (rst)
        (take && frm_len < MIN_L) |=> !dsc_rd_req);

    p_wb_word_r5: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> (!wb_ctl[OWN_BIT] && wb_ctl[9:8] == 2'b11));

    p_ptr_move_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(wb_req && wb_done) && !$past(base_wr))
        |-> (cur_ptr == base_q || cur_ptr == $past(cur_ptr) + STEP));

    p_single_req_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dsc_rd_req, pay_req, wb_req}));

    p_pay_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (pay_req && !pay_done) |=> pay_req);
endmodule

// File: rtl/rxd_stats.sv
module rxd_stats
    import rxd_pkg::*;
#(
    parameter int LW = 16,
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_valid,
    input  rxd_ev_e       ev_kind,
    input  logic [LW-1:0] ev_len,
    input  rxd_class_e    ev_cls,
    output logic [CW-1:0] cnt_frames,
    output logic [CW-1:0] cnt_bytes,
    output logic [CW-1:0] cnt_mcast,
    output logic [CW-1:0] cnt_bcast
);
    localparam int NCNT = 4;

    logic          good;
    logic [CW-1:0] inc [NCNT];
    logic [CW-1:0] cnt [NCNT];

    assign good = ev_valid && (ev_kind == EV_GOOD);

    always_comb begin
        inc[0] = CW'(1);
        inc[1] = CW'(ev_len) + CW'(CRC_PAD);
        inc[2] = CW'(ev_cls == CL_MCAST);
        inc[3] = CW'(ev_cls == CL_BCAST);
    end

    for (genvar k = 0; k < NCNT; k++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)
                cnt[k] <= '0;
            else if (good)
                cnt[k] <= cnt[k] + inc[k];
        end
    end

    assign cnt_frames = cnt[0];
    assign cnt_bytes  = cnt[1];
    assign cnt_mcast  = cnt[2];
    assign cnt_bcast  = cnt[3];

    p_frames_step_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_frames) |-> (cnt_frames == $past(cnt_frames) + CW'(1)));

    p_class_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(!$stable(cnt_mcast) && !$stable(cnt_bcast)));
endmodule

// File: rtl/rxd_status.sv
module rxd_status
    import rxd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_valid,
    input  rxd_ev_e    ev_kind,
    input  logic [3:0] sts_clr,
    output logic [3:0] sts
);
    rxd_sts_t set_v;
    logic [3:0] sts_q;

    assign set_v = ev_valid ? sts_for(ev_kind) : '0;

    for (genvar i = 0; i < 4; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                sts_q[i] <= 1'b0;
            else if (set_v[i])
                sts_q[i] <= 1'b1;
            else if (sts_clr[i])
                sts_q[i] <= 1'b0;
        end

        p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
            (sts_q[i] && !sts_clr[i]) |=> sts_q[i]);
    end

    assign sts = sts_q;
endmodule

// File: rtl/rx_desc_engine.sv
module rx_desc_engine
    import rxd_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LW         = 16,
    parameter int CW         = 64,
    parameter int DESC_BYTES = 32,
    parameter int MIN_LEN    = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   dma_ctrl,
    input  logic          base_wr,
    input  logic [AW-1:0] base_data,
    output logic [AW-1:0] cur_ptr,
    input  logic          frm_valid,
    output logic          frm_ready,
    input  logic [LW-1:0] frm_len,
    input  logic [47:0]   frm_dst,
    output logic          dsc_rd_req,
    output logic [AW-1:0] dsc_rd_addr,
    input  logic          dsc_rd_ack,
    input  logic [31:0]   dsc_rd_ctl,
    input  logic [15:0]   dsc_rd_b1size,
    input  logic [AW-1:0] dsc_rd_b1addr,
    output logic          pay_req,
    output logic [AW-1:0] pay_addr,
    output logic [LW-1:0] pay_len,
    input  logic          pay_done,
    output logic          wb_req,
    output logic [AW-1:0] wb_addr,
    output logic [31:0]   wb_ctl,
    input  logic          wb_done,
    output logic [3:0]    sts,
    input  logic [3:0]    sts_clr,
    output logic [CW-1:0] cnt_frames,
    output logic [CW-1:0] cnt_bytes,
    output logic [CW-1:0] cnt_mcast,
    output logic [CW-1:0] cnt_bcast
);
    logic          ev_valid;
    rxd_ev_e       ev_kind;
    logic [LW-1:0] ev_len;
    logic [47:0]   ev_dst;
    rxd_class_e    ev_cls;

    rxd_seq #(
        .AW(AW), .LW(LW), .DESC_BYTES(DESC_BYTES), .MIN_LEN(MIN_LEN)
    ) u_seq (
        .clk(clk), .rst(rst), .dma_ctrl(dma_ctrl),
        .base_wr(base_wr), .base_data(base_data), .cur_ptr(cur_ptr),
        .frm_valid(frm_valid), .frm_ready(frm_ready),
        .frm_len(frm_len), .frm_dst(frm_dst),
        .dsc_rd_req(dsc_rd_req), .dsc_rd_addr(dsc_rd_addr),
        .dsc_rd_ack(dsc_rd_ack), .dsc_rd_ctl(dsc_rd_ctl),
        .dsc_rd_b1size(dsc_rd_b1size), .dsc_rd_b1addr(dsc_rd_b1addr),
        .pay_req(pay_req), .pay_addr(pay_addr), .pay_len(pay_len),
        .pay_done(pay_done),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_ctl(wb_ctl),
        .wb_done(wb_done),
        .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_len(ev_len), .ev_dst(ev_dst)
    );

    rxd_classify u_cls (
        .dst(ev_dst),
        .cls(ev_cls)
    );

    rxd_stats #(.LW(LW), .CW(CW)) u_stats (
        .clk(clk), .rst(rst),
        .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_len(ev_len), .ev_cls(ev_cls),
        .cnt_frames(cnt_frames), .cnt_bytes(cnt_bytes),
        .cnt_mcast(cnt_mcast), .cnt_bcast(cnt_bcast)
    );

    rxd_status u_sts (
        .clk(clk), .rst(rst),
        .ev_valid(ev_valid), .ev_kind(ev_kind),
        .sts_clr(sts_clr), .sts(sts)
    );

    p_nodesc_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (dsc_rd_req && dsc_rd_ack && !dsc_rd_ctl[OWN_BIT]) |=> (!pay_req && !wb_req));
endmodule

// File: tb/tb_rx_desc_engine.sv
module tb_rx_desc_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] dma_ctrl = '0;
    logic        base_wr = 1'b0;
    logic [31:0] base_data = '0;
    logic [31:0] cur_ptr;
    logic        frm_valid = 1'b0;
    logic        frm_ready;
    logic [15:0] frm_len = '0;
    logic [47:0] frm_dst = '0;
    logic        dsc_rd_req;
    logic [31:0] dsc_rd_addr;
    logic        dsc_rd_ack = 1'b0;
    logic [31:0] dsc_rd_ctl = '0;
    logic [15:0] dsc_rd_b1size = '0;
    logic [31:0] dsc_rd_b1addr = '0;
    logic        pay_req;
    logic [31:0] pay_addr;
    logic [15:0] pay_len;
    logic        pay_done = 1'b0;
    logic        wb_req;
    logic [31:0] wb_addr;
    logic [31:0] wb_ctl;
    logic        wb_done = 1'b0;
    logic [3:0]  sts;
    logic [3:0]  sts_clr = '0;
    logic [63:0] cnt_frames, cnt_bytes, cnt_mcast, cnt_bcast;

    int n_chk = 0;
    int n_err = 0;
    logic [63:0] e_frames = 0, e_bytes = 0, e_mc = 0, e_bc = 0;
    logic [31:0] e_ptr = 0, e_base = 0;

    always #10 clk = ~clk;

    rx_desc_engine dut (
        .clk(clk), .rst(rst), .dma_ctrl(dma_ctrl),
        .base_wr(base_wr), .base_data(base_data), .cur_ptr(cur_ptr),
        .frm_valid(frm_valid), .frm_ready(frm_ready),
        .frm_len(frm_len), .frm_dst(frm_dst),
        .dsc_rd_req(dsc_rd_req), .dsc_rd_addr(dsc_rd_addr),
        .dsc_rd_ack(dsc_rd_ack), .dsc_rd_ctl(dsc_rd_ctl),
        .dsc_rd_b1size(dsc_rd_b1size), .dsc_rd_b1addr(dsc_rd_b1addr),
        .pay_req(pay_req), .pay_addr(pay_addr), .pay_len(pay_len),
        .pay_done(pay_done),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_ctl(wb_ctl),
        .wb_done(wb_done),
        .sts(sts), .sts_clr(sts_clr),
        .cnt_frames(cnt_frames), .cnt_bytes(cnt_bytes),
        .cnt_mcast(cnt_mcast), .cnt_bcast(cnt_bcast)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_counters(input string tag);
        chk({tag, " frames"}, cnt_frames, e_frames);
        chk({tag, " bytes"},  cnt_bytes,  e_bytes);
        chk({tag, " mcast"},  cnt_mcast,  e_mc);
        chk({tag, " bcast"},  cnt_bcast,  e_bc);
    endtask

    task automatic clear_sts();
        @(negedge clk);
        sts_clr = 4'hF;
        @(negedge clk);
        sts_clr = 4'h0;
        chk("R9 status cleared", {60'd0, sts}, 64'd0);
    endtask

    task automatic offer(input logic [15:0] len, input logic [47:0] dst);
        @(negedge clk);
        frm_len   = len;
        frm_dst   = dst;
        frm_valid = 1'b1;
        while (!frm_ready) @(negedge clk);
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic load_base(input logic [31:0] b);
        @(negedge clk);
        base_wr   = 1'b1;
        base_data = b;
        @(negedge clk);
        base_wr   = 1'b0;
        e_base = b;
        e_ptr  = b;
        chk("R6 base write loads pointer", {32'd0, cur_ptr}, {32'd0, b});
    endtask

    // Good frame through an owned descriptor
    task automatic t_good(input string name, input logic [15:0] len, input logic [47:0] dst,
                          input logic [15:0] b1size, input logic [31:0] b1addr);
        logic is_uni, is_bc;
        clear_sts();
        offer(len, dst);
        while (!dsc_rd_req) @(negedge clk);
        chk({"R3 fetch addr ", name}, {32'd0, dsc_rd_addr}, {32'd0, e_ptr});
        dsc_rd_ack    = 1'b1;
        dsc_rd_ctl    = 32'h8000_0000;
        dsc_rd_b1size = b1size;
        dsc_rd_b1addr = b1addr;
        @(negedge clk);
        dsc_rd_ack = 1'b0;
        while (!pay_req) @(negedge clk);
        chk({"R4 pay addr ", name}, {32'd0, pay_addr}, {32'd0, b1addr});
        chk({"R4 pay len ", name},  {48'd0, pay_len},  {48'd0, len});
        chk({"R10 one req ", name}, {62'd0, dsc_rd_req, wb_req}, 64'd0);
        repeat (2) @(negedge clk);
        chk({"R10 pay held ", name}, {63'd0, pay_req}, 64'd1);
        pay_done = 1'b1;
        @(negedge clk);
        pay_done = 1'b0;
        while (!wb_req) @(negedge clk);
        chk({"R5 wb addr ", name}, {32'd0, wb_addr}, {32'd0, e_ptr});
        chk({"R5 wb word ", name}, {32'd0, wb_ctl},
            {32'd0, (32'(len) + 32'd4) << 16 | 32'h0000_0300});
        wb_done = 1'b1;
        @(negedge clk);
        wb_done = 1'b0;
        while (!frm_ready) @(negedge clk);
        e_ptr = b1size[15] ? e_base : e_ptr + 32'd32;
        is_uni = !dst[0];
        is_bc  = (dst == 48'hFFFF_FFFF_FFFF);
        e_frames = e_frames + 1;
        e_bytes  = e_bytes + 64'(len) + 64'd4;
        if (!is_uni && is_bc) e_bc = e_bc + 1;
        if (!is_uni && !is_bc) e_mc = e_mc + 1;
        chk({"R6 next ptr ", name}, {32'd0, cur_ptr}, {32'd0, e_ptr});
        chk_counters({"R7 R8 ", name});
        chk({"R9 status ", name}, {60'd0, sts}, 64'h3);
    endtask

    task automatic t_short();
        logic saw;
        clear_sts();
        offer(16'd11, 48'h0000_0000_0002);
        saw = 1'b0;
        repeat (5) begin
            if (dsc_rd_req) saw = 1'b1;
            @(negedge clk);
        end
        chk("R2 no fetch for short frame", {63'd0, saw}, 64'd0);
        chk("R2 status for short frame", {60'd0, sts}, 64'h3);
        chk("R2 pointer unchanged", {32'd0, cur_ptr}, {32'd0, e_ptr});
        chk_counters("R2 short");
    endtask

    task automatic t_nodesc();
        logic saw;
        clear_sts();
        offer(16'd64, 48'h0000_0000_0004);
        while (!dsc_rd_req) @(negedge clk);
        chk("R3 fetch addr nodesc", {32'd0, dsc_rd_addr}, {32'd0, e_ptr});
        dsc_rd_ack    = 1'b1;
        dsc_rd_ctl    = 32'h7FFF_FFFF;
        dsc_rd_b1size = 16'h8600;
        dsc_rd_b1addr = 32'h3000_0000;
        @(negedge clk);
        dsc_rd_ack = 1'b0;
        saw = 1'b0;
        repeat (5) begin
            if (pay_req || wb_req) saw = 1'b1;
            @(negedge clk);
        end
        chk("R3 no payload or writeback", {63'd0, saw}, 64'd0);
        chk("R3 status buffer unavailable", {60'd0, sts}, 64'hC);
        chk("R3 pointer unchanged", {32'd0, cur_ptr}, {32'd0, e_ptr});
        chk_counters("R3 nodesc");
    endtask

    task automatic t_disabled();
        logic saw;
        clear_sts();
        @(negedge clk);
        dma_ctrl  = 32'hFFFF_FFFD;
        frm_len   = 16'd60;
        frm_dst   = 48'h0;
        frm_valid = 1'b1;
        saw = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (frm_ready || dsc_rd_req) saw = 1'b1;
        end
        frm_valid = 1'b0;
        @(negedge clk);
        dma_ctrl = 32'h0000_0002;
        @(negedge clk);
        chk("R1 no accept while disabled", {63'd0, saw}, 64'd0);
        chk("R1 ready once enabled", {63'd0, frm_ready}, 64'd1);
        chk("R1 status untouched", {60'd0, sts}, 64'd0);
        chk_counters("R1 disabled");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset ready low", {63'd0, frm_ready}, 64'd0);
        chk("R9 reset status", {60'd0, sts}, 64'd0);
        chk("R6 reset pointer", {32'd0, cur_ptr}, 64'd0);
        chk_counters("R8 reset");
        dma_ctrl = 32'h0000_0002;
        load_base(32'h1000_0000);
        t_good("unicast", 16'd60, 48'h5544_3322_1100, 16'h0600, 32'h2000_0000);
        t_good("bcast len12", 16'd12, 48'hFFFF_FFFF_FFFF, 16'h0600, 32'h2000_1000);
        t_good("mcast wrap", 16'd100, 48'h0100_005E_0001, 16'h8600, 32'h2000_2000);
        t_short();
        t_nodesc();
        t_good("near-bcast", 16'd200, 48'hFEFF_FFFF_FFFF, 16'h0200, 32'h2000_3000);
        t_disabled();
        load_base(32'h4000_0040);
        t_good("after base", 16'd1500, 48'h0000_0000_0010, 16'h8000, 32'h2000_4000);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule